// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel

This block is one channel of a general-purpose timer. Three copies are meant to sit side by side behind one register block. Each copy takes the free-running input clock and can divide it by a power of two. It then counts up or down. The count wraps either across the full 16-bit range or at a programmable interval limit. On every step it compares the count against a set of match values. Wraps and matches raise sticky status flags, which the register block reads and clears.

The register block drives the clock configuration, the interval limit, the match values and a status-clear strobe as plain levels. The channel keeps its own control register, which is loaded by a write strobe and read back on `ctl_o`. It reports the live count and the status vector. No interface carries a data stream, so there is no valid/ready handshake: every pin is a plain control or status level, and every output is valid in each cycle after reset.

Top module: `timer_channel`

## Requirements
- R1: `clk_cfg_i[0]` enables the prescaler and `clk_cfg_i[4:1]` holds N. With the prescaler on, the counter may step once every 2^(N+1) clocks. With it off, the counter may step on every clock.
- R2: While control bit 0 (halt) is set, the count keeps its value.
- R3: Counting up, a count that has reached or passed the top of the range returns to 0 on its next step. The top is `interval_i` when control bit 1 is set, so the cycle length is interval+1. Otherwise the top is 0xFFFF.
- R4: Control bit 2 selects down-counting. A down step from 0 loads the top of the active range.
- R5: A wrap sets status bit 0 when control bit 1 is set, and status bit 4 when it is clear.
- R6: A step that lands on match value i sets status bit i+1, for i = 0..2. The match values are packed into `match_i` with value i at bits [16i+15:16i]. A match value above the active top never sets its bit.
- R7: A control write with bit 4 set forces the count to 0 on that edge. Bit 4 is never stored and reads back as 0; bits 0,1,2,3,5 are stored as written.
- R8: Status bit 5 always reads 0.
- R9: After reset, `ctl_o` is 0x21, the count is 0 and the status is 0.
- R10: A status bit stays set until `status_clr_i`. When a clear and a set event fall in the same cycle, the set event wins.
- R11: The prescaler restarts its division from zero in the cycle it becomes enabled, and in any cycle where N changes while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cfg_i | input | 5 | Bit 0 prescale enable, bits 4:1 prescale exponent N |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control write data: 0 halt, 1 interval mode, 2 down, 4 zero count |
| ctl_o | output | 6 | Stored control register |
| interval_i | input | 16 | Interval limit |
| match_i | input | 48 | Three match values, value i at [16i+15:16i] |
| status_clr_i | input | 1 | Clears all status bits |
| count_o | output | 16 | Current count |
| status_o | output | 6 | Sticky flags: 0 interval wrap, 3:1 matches, 4 overflow, 5 reserved |

## Verification
The embedded assertions check on every cycle that the prescaler never produces two steps in a row once division is enabled. They also check that a halted count stays put, that an in-range interval count never leaves its range, that a zeroing write always lands on 0, and that status bits only disappear after a clear. Other behaviours depend on long sequences and on exact cycle placement, and only the bench's scenarios can show them. These include the exact prescale periods, the restart after a change of N, the wrap targets in both directions, which match values fire and which are ignored above the top, and the set-over-clear priority. The bench covers them with a behavioural model that is compared against the design on every clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef struct packed {
    logic keep5;
    logic zero_req;
    logic keep3;
    logic down;
    logic iv_mode;
    logic halt;
  } ctl_t;

  localparam logic [5:0] CTL_RESET = 6'h21;
  localparam logic [5:0] CTL_STORE = 6'h2F;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [PS_BITS-1:0] sel_i,
  output logic               tick_o
);
  localparam int PCW = 1 << PS_BITS;

  logic [PCW-1:0]     pcnt_q;
  logic [PCW-1:0]     mask;
  logic               prev_en_q;
  logic [PS_BITS-1:0] prev_sel_q;
  logic               restart;

  always_comb begin
    for (int b = 0; b < PCW; b++) mask[b] = (b <= int'(sel_i));
  end

  assign restart = en_i && (!prev_en_q || (sel_i != prev_sel_q));
  assign tick_o  = en_i ? (!restart && (pcnt_q == mask)) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q     <= '0;
      prev_en_q  <= 1'b0;
      prev_sel_q <= '0;
    end else begin
      prev_en_q  <= en_i;
      prev_sel_q <= sel_i;
      if (!en_i || restart || tick_o) pcnt_q <= '0;
      else                            pcnt_q <= pcnt_q + PCW'(1);
    end
  end

  // R1: with division enabled, two steps never fall in consecutive cycles
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_o) |=> (!en_i || !tick_o));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 16
) (
  input  logic         step_i,
  input  logic [W-1:0] next_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] value_i,
  output logic         hit_o
);
  assign hit_o = step_i && (next_i == value_i) && (value_i <= top_i);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         ctl_wr_i,
  input  logic [5:0]   ctl_wdata_i,
  input  logic [W-1:0] interval_i,
  output ctl_t         ctl_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] next_o,
  output logic [W-1:0] top_o,
  output logic         step_o,
  output logic         wrap_o
);
  ctl_t         ctl_q;
  ctl_t         ctl_nxt;
  logic [W-1:0] count_q;
  logic         zero_now;
  logic         at_edge;

  always_comb begin
    ctl_nxt          = ctl_t'(ctl_wdata_i & CTL_STORE);
    ctl_nxt.zero_req = 1'b0;
  end

  assign zero_now = ctl_wr_i && ctl_wdata_i[4];
  assign top_o    = ctl_q.iv_mode ? interval_i : {W{1'b1}};
  assign step_o   = tick_i && !ctl_q.halt && !zero_now;

  always_comb begin
    if (ctl_q.down) begin
      at_edge = (count_q == '0);
      next_o  = at_edge ? top_o : count_q - W'(1);
    end else begin
      at_edge = (count_q >= top_o);
      next_o  = at_edge ? '0 : count_q + W'(1);
    end
  end

  assign wrap_o  = step_o && at_edge;
  assign ctl_o   = ctl_q;
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= ctl_t'(CTL_RESET);
      count_q <= '0;
    end else begin
      if (ctl_wr_i) ctl_q <= ctl_nxt;
      if (zero_now)    count_q <= '0;
      else if (step_o) count_q <= next_o;
    end
  end

  a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.halt && !ctl_wr_i) |=> $stable(count_q));

  a_r7_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && ctl_wdata_i[4]) |=> (count_q == '0));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.iv_mode && !ctl_wr_i && (count_q <= interval_i)) |=> (count_q <= $past(interval_i)));
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wrap_i,
  input  logic          iv_mode_i,
  input  logic [NM-1:0] hit_i,
  output logic [NM+2:0] status_o
);
  logic [NM+2:0] set_v;
  logic [NM+2:0] status_q;

  always_comb begin
    set_v         = '0;
    set_v[0]      = wrap_i && iv_mode_i;
    set_v[NM:1]   = hit_i;
    set_v[NM+1]   = wrap_i && !iv_mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (clr_i ? '0 : status_q) | set_v;
  end

  assign status_o = status_q;

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PS_BITS   = 4,
  parameter int NUM_MATCH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PS_BITS:0]             clk_cfg_i,
  input  logic                         ctl_wr_i,
  input  logic [5:0]                   ctl_wdata_i,
  output logic [5:0]                   ctl_o,
  input  logic [CNT_W-1:0]             interval_i,
  input  logic [NUM_MATCH*CNT_W-1:0]   match_i,
  input  logic                         status_clr_i,
  output logic [CNT_W-1:0]             count_o,
  output logic [NUM_MATCH+2:0]         status_o
);
  logic             tick;
  ctl_t             ctl;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] top;
  logic             step;
  logic             wrap;
  logic [NUM_MATCH-1:0] hits;

  tmr_prescaler #(.PS_BITS(PS_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .en_i(clk_cfg_i[0]), .sel_i(clk_cfg_i[PS_BITS:1]),
    .tick_o(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .interval_i(interval_i),
    .ctl_o(ctl), .count_o(count_o), .next_o(nxt), .top_o(top),
    .step_o(step), .wrap_o(wrap)
  );

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    tmr_match #(.W(CNT_W)) u_m (
      .step_i(step), .next_i(nxt), .top_i(top),
      .value_i(match_i[i*CNT_W +: CNT_W]), .hit_o(hits[i])
    );
  end

  tmr_status #(.NM(NUM_MATCH)) u_st (
    .clk(clk), .rst_n(rst_n), .clr_i(status_clr_i),
    .wrap_i(wrap), .iv_mode_i(ctl.iv_mode), .hit_i(hits),
    .status_o(status_o)
  );

  assign ctl_o = ctl;
endmodule

// File: tb/timer_channel_test.sv
module timer_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  clk_cfg = '0;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic [5:0]  ctl_o;
  logic [15:0] interval = '0;
  logic [15:0] mv [3];
  logic        clr = 1'b0;
  logic [15:0] count_o;
  logic [5:0]  status_o;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  string phase = "R9";

  int m_cnt, m_stat, m_ctl, m_pc, m_pen, m_pn;

  always #2 clk = ~clk;

  timer_channel uut (
    .clk(clk), .rst_n(rst_n), .clk_cfg_i(clk_cfg),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_o(ctl_o),
    .interval_i(interval), .match_i({mv[2], mv[1], mv[0]}),
    .status_clr_i(clr), .count_o(count_o), .status_o(status_o)
  );

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_stat = 0; m_ctl = 'h21; m_pc = 0; m_pen = 0; m_pn = 0;
    end else begin
      int en, n, rs, tk, top, zero, go, nx, set, wrapped;
      en = clk_cfg[0]; n = clk_cfg[4:1];
      rs = en && (!m_pen || n != m_pn);
      tk = !en ? 1 : (!rs && m_pc == (1 << (n + 1)) - 1);
      m_pc = (!en || rs || tk) ? 0 : m_pc + 1;
      m_pen = en; m_pn = n;
      top = (m_ctl & 2) ? int'(interval) : 65535;
      zero = ctl_wr && ctl_wdata[4];
      go = tk && !(m_ctl & 1) && !zero;
      set = 0; nx = m_cnt; wrapped = 0;
      if (go) begin
        if (m_ctl & 4) begin
          if (m_cnt == 0) begin nx = top; wrapped = 1; end
          else nx = m_cnt - 1;
        end else begin
          if (m_cnt >= top) begin nx = 0; wrapped = 1; end
          else nx = m_cnt + 1;
        end
        if (wrapped) set |= (m_ctl & 2) ? 1 : 16;
        for (int i = 0; i < 3; i++)
          if (nx == int'(mv[i]) && int'(mv[i]) <= top) set |= (2 << i);
      end
      m_stat = (clr ? 0 : m_stat) | set;
      if (zero) m_cnt = 0; else if (go) m_cnt = nx;
      if (ctl_wr) m_ctl = ctl_wdata & 'h2F;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({phase, " count"}, int'(count_o), m_cnt);
      chk({phase, " status"}, int'(status_o), m_stat);
      chk({phase, " control"}, int'(ctl_o), m_ctl);
    end
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr_ctl(logic [5:0] v, logic with_clr);
    ctl_wr = 1'b1; ctl_wdata = v; clr = with_clr;
    @(negedge clk);
    ctl_wr = 1'b0; clr = 1'b0;
  endtask

  task automatic gap(output int g);
    logic [15:0] c0;
    c0 = count_o;
    while (count_o == c0) @(negedge clk);
    c0 = count_o; g = 0;
    while (count_o == c0) begin @(negedge clk); g++; end
  endtask

  initial begin
    #(4 * 190000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int g, held;
    mv[0] = 16'd3; mv[1] = 16'd5; mv[2] = 16'd9;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    chk("R9 reset control", int'(ctl_o), 'h21);
    chk("R9 reset count", int'(count_o), 0);
    chk("R9 reset status", int'(status_o), 0);

    // prescaled up count, N=1 then N=2
    phase = "R1";
    clk_cfg = 5'b00011;
    wr_ctl(6'h10, 1'b0);
    gap(g); chk("R1 period N=1", g, 4);
    cyc(7);
    phase = "R11";
    clk_cfg = 5'b00101;
    cyc(20);
    gap(g); chk("R11 period N=2", g, 8);
    clk_cfg = 5'b00000;
    cyc(5);

    // halt keeps the count
    phase = "R2";
    wr_ctl(6'h01, 1'b0);
    held = int'(count_o);
    cyc(20);
    chk("R2 halted count", int'(count_o), held);

    // zeroing write, bit 4 not stored
    phase = "R7";
    wr_ctl(6'h3F, 1'b0);
    chk("R7 readback", int'(ctl_o), 'h2F);
    chk("R7 zeroed count", int'(count_o), 0);

    // clear while halted
    phase = "R10";
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R10 clear", int'(status_o), 0);

    // interval mode with matches, 9 lies above interval 5
    phase = "R6";
    interval = 16'd5;
    wr_ctl(6'h12, 1'b1);
    cyc(12);
    chk("R5 interval wrap bit0", int'(status_o[0]), 1);
    chk("R6 match0 bit1", int'(status_o[1]), 1);
    chk("R6 match1 bit2", int'(status_o[2]), 1);
    chk("R6 match2 above top bit3", int'(status_o[3]), 0);
    chk("R5 no overflow bit4", int'(status_o[4]), 0);

    // set beats clear while clear is held
    phase = "R10";
    clr = 1'b1; cyc(14); clr = 1'b0;
    cyc(3);

    // down counting in both ranges
    phase = "R4";
    wr_ctl(6'h16, 1'b1);
    @(negedge clk);
    chk("R4 down wrap to interval", int'(count_o), 5);
    chk("R5 down interval wrap", int'(status_o[0]), 1);
    cyc(8);
    wr_ctl(6'h14, 1'b1);
    @(negedge clk);
    chk("R4 down wrap to full top", int'(count_o), 'hFFFF);
    chk("R5 down overflow bit4", int'(status_o[4]), 1);
    cyc(4);

    // full-range up wrap
    phase = "R3";
    wr_ctl(6'h10, 1'b1);
    cyc(65535);
    chk("R3 top reached", int'(count_o), 'hFFFF);
    chk("R3 no overflow yet", int'(status_o[4]), 0);
    @(negedge clk);
    chk("R3 wrapped to zero", int'(count_o), 0);
    chk("R5 overflow bit4", int'(status_o[4]), 1);
    chk("R8 reserved bit5", int'(status_o[5]), 0);

    cmp_on = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule